// File: doc/BRIEF.md
# MDIO Link Status Poller

This block keeps a live picture of which PHYs on a management bus are present and which have link. Once scanning is switched on, it walks the PHY addresses in ascending order. For every address that software has enabled, it asks a shared MDIO frame engine to read the PHY's status register. From the reply it records two things: whether the PHY acknowledged the read (the alive bitmap) and the link-up bit of the returned word (the link bitmap). The serial MDC/MDIO framing is left to the frame engine. The poller talks to it through a level request that is held until a one-cycle done pulse comes back, carrying the acknowledge and the read data.

Two monitor channels watch single PHYs for link changes. Each channel takes its link state either from a dedicated external link pin or from the polled link bitmap. A change on a channel raises that channel's raw interrupt bit, and the masked copy of that bit follows only when the channel's interrupt is enabled. In the alternative any-change mode, the channels stop raising interrupts. Instead, any polled PHY whose link bit flips raises raw bit 0. Register reads started by the host elsewhere are reported on a strobe, and they refresh the alive bitmap as well.

Top module: `mdio_link_poller`

## Requirements
- R1: After reset, `req` is 0 and `link_map`, `alive_map` and `int_raw` are all 0. While `scan_en` is 0 and no request is outstanding, no request is issued.
- R2: Requests read register address 1 (`req_reg` = 1). Addresses are visited in ascending order and wrap from 31 to 0. Once raised, `req` stays high with a stable `req_phy` until `done` is seen. The scan moves on only after `done`.
- R3: Only addresses whose `poll_mask` bit is 1 are requested. When the mask is all zero, `req` never rises.
- R4: On `done` with `ack`=1, both bitmap bits of that PHY are written at the same clock edge: the alive bit becomes 1 and the link bit becomes bit 2 of `rd_data`.
- R5: On `done` with `ack`=0, the PHY's alive bit is cleared and the link bitmap is left unchanged.
- R6: A `host_rd_vld` strobe writes `host_rd_ack` into the alive bit of `host_rd_phy`. If a poll completes on the same address in the same cycle, the poll result wins.
- R7: Channel n's link state is `link_pin[n]` when `mon_sel[n]`=1. When `mon_sel[n]`=0, it is the `link_map` bit addressed by that channel's `mon_phy` field.
- R8: When `any_change_mode`=0, a change in channel n's link state sets `int_raw[n]` at the next clock edge. The tracked channel state is 0 at reset.
- R9: `int_masked[n]` is 1 exactly when `int_raw[n]` is 1 and `mon_int_en[n]` is 1.
- R10: When `any_change_mode`=1, channel changes set no raw bit. Instead, an acknowledged poll whose link bit differs from the stored `link_map` bit sets `int_raw[0]`.
- R11: When `int_clr_vld` is 1, each 1 bit of `int_clr` clears the matching `int_raw` bit. A new set in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_en | input | 1 | Global scan enable |
| any_change_mode | input | 1 | 1: any polled link change raises raw bit 0 |
| poll_mask | input | 32 | Per-address poll enable |
| mon_sel | input | 2 | Per channel: 1 = link pin, 0 = polled bitmap |
| mon_int_en | input | 2 | Per-channel interrupt enable for the masked outputs |
| mon_phy0 | input | 5 | PHY address watched by channel 0 |
| mon_phy1 | input | 5 | PHY address watched by channel 1 |
| link_pin | input | 2 | External link pins for the two channels |
| req | output | 1 | Read request to the frame engine, held until done |
| req_phy | output | 5 | PHY address of the request |
| req_reg | output | 5 | Register address of the request (status register) |
| done | input | 1 | Frame engine completion pulse |
| ack | input | 1 | PHY acknowledged the read, valid with done |
| rd_data | input | 16 | Read data, valid with done |
| host_rd_vld | input | 1 | Host-initiated read completed |
| host_rd_phy | input | 5 | PHY address of the host read |
| host_rd_ack | input | 1 | Acknowledge of the host read |
| int_clr_vld | input | 1 | Apply an interrupt clear |
| int_clr | input | 2 | Write-one-to-clear mask for `int_raw` |
| link_map | output | 32 | Polled link state per PHY |
| alive_map | output | 32 | Acknowledge state per PHY |
| int_raw | output | 2 | Raw link-change interrupts |
| int_masked | output | 2 | Enabled copy of the raw interrupts |

## Verification
The scan is exercised with a full mask over two complete passes. In these passes, acknowledge and link values are derived arithmetically from the address and the pass number, and the hold time before `done` varies. This separates ordering and wrap-around faults from faults in the acknowledge and link update rules. Sparse masks that include the wrap at address 31, plus an all-zero mask, show whether the skip logic and the idle behaviour are correct. On the interrupt side, the bench toggles pins, moves a polled channel between a link-down and a link-up PHY, and applies a clear in the same cycle as a set. This tells the pin source apart from the polled source, and enabled channels apart from disabled ones. In any-change mode, the bench completes polls that keep, flip, or fail to acknowledge the link bit, so real changes can be told apart from repeated values and from missing replies.

// File: rtl/mdio_link_poller.sv
module mdio_link_poller #(
  parameter int N_PHY    = 32,
  parameter int STAT_REG = 1,
  parameter int LINK_BIT = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scan_en,
  input  logic                      any_change_mode,
  input  logic [N_PHY-1:0]          poll_mask,
  input  logic [1:0]                mon_sel,
  input  logic [1:0]                mon_int_en,
  input  logic [$clog2(N_PHY)-1:0]  mon_phy0,
  input  logic [$clog2(N_PHY)-1:0]  mon_phy1,
  input  logic [1:0]                link_pin,
  output logic                      req,
  output logic [$clog2(N_PHY)-1:0]  req_phy,
  output logic [4:0]                req_reg,
  input  logic                      done,
  input  logic                      ack,
  input  logic [15:0]               rd_data,
  input  logic                      host_rd_vld,
  input  logic [$clog2(N_PHY)-1:0]  host_rd_phy,
  input  logic                      host_rd_ack,
  input  logic                      int_clr_vld,
  input  logic [1:0]                int_clr,
  output logic [N_PHY-1:0]          link_map,
  output logic [N_PHY-1:0]          alive_map,
  output logic [1:0]                int_raw,
  output logic [1:0]                int_masked
);
  localparam int AW = $clog2(N_PHY);

  logic          busy;
  logic [AW-1:0] ptr;
  logic [1:0]    prev_link;
  logic [1:0]    chan_link;

  wire          rd_link   = rd_data[LINK_BIT];
  wire          poll_fire = busy & done;
  wire [AW-1:0] ptr_inc   = (ptr == AW'(N_PHY - 1)) ? '0 : ptr + 1'b1;

  logic unused_rd;
  assign unused_rd = ^(rd_data & ~(16'd1 << LINK_BIT));

  assign req     = busy;
  assign req_phy = ptr;
  assign req_reg = 5'(STAT_REG);

  assign chan_link[0] = mon_sel[0] ? link_pin[0] : link_map[mon_phy0];
  assign chan_link[1] = mon_sel[1] ? link_pin[1] : link_map[mon_phy1];

  wire       any_chg = poll_fire & ack & (rd_link != link_map[ptr]);
  wire [1:0] set_v   = any_change_mode ? {1'b0, any_chg} : (chan_link ^ prev_link);
  wire [1:0] clr_v   = int_clr_vld ? int_clr : 2'b00;

  assign int_masked = int_raw & mon_int_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      ptr       <= '0;
      link_map  <= '0;
      alive_map <= '0;
      prev_link <= '0;
      int_raw   <= '0;
    end else begin
      prev_link <= chan_link;
      int_raw   <= (int_raw & ~clr_v) | set_v;
      if (host_rd_vld) alive_map[host_rd_phy] <= host_rd_ack;
      if (busy) begin
        if (done) begin
          busy           <= 1'b0;
          ptr            <= ptr_inc;
          alive_map[ptr] <= ack;
          if (ack) link_map[ptr] <= rd_link;
        end
      end else if (scan_en) begin
        if (poll_mask[ptr]) busy <= 1'b1;
        else                ptr  <= ptr_inc;
      end
    end
  end
endmodule

// File: rtl/mdio_link_poller_chk.sv
module mdio_link_poller_chk #(
  parameter int N_PHY = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     scan_en,
  input logic [N_PHY-1:0]         poll_mask,
  input logic                     req,
  input logic [$clog2(N_PHY)-1:0] req_phy,
  input logic                     done,
  input logic                     ack,
  input logic [N_PHY-1:0]         link_map,
  input logic [N_PHY-1:0]         alive_map
);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && !scan_en) |=> !req);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !done) |=> (req && $stable(req_phy)));

  p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(poll_mask[req_phy]));

  p_alive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && done) |=> (alive_map[$past(req_phy)] == $past(ack)));

  p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && done && !ack) |=> (link_map == $past(link_map)));
endmodule

bind mdio_link_poller mdio_link_poller_chk #(.N_PHY(N_PHY)) u_chk (
  .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .poll_mask(poll_mask),
  .req(req), .req_phy(req_phy), .done(done), .ack(ack),
  .link_map(link_map), .alive_map(alive_map)
);

// File: tb/mdio_link_poller_test.sv
module mdio_link_poller_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_en = 1'b0, any_change_mode = 1'b0;
  logic [31:0] poll_mask = '0;
  logic [1:0]  mon_sel = '0, mon_int_en = '0, link_pin = '0;
  logic [4:0]  mon_phy0 = '0, mon_phy1 = '0;
  logic        req;
  logic [4:0]  req_phy, req_reg;
  logic        done = 1'b0, ack = 1'b0;
  logic [15:0] rd_data = '0;
  logic        host_rd_vld = 1'b0, host_rd_ack = 1'b0;
  logic [4:0]  host_rd_phy = '0;
  logic        int_clr_vld = 1'b0;
  logic [1:0]  int_clr = '0;
  logic [31:0] link_map, alive_map;
  logic [1:0]  int_raw, int_masked;

  int n_run = 0, n_fail = 0;
  logic [31:0] elink = '0, ealive = '0;

  always #2 clk = ~clk;

  mdio_link_poller uut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .any_change_mode(any_change_mode),
    .poll_mask(poll_mask), .mon_sel(mon_sel), .mon_int_en(mon_int_en),
    .mon_phy0(mon_phy0), .mon_phy1(mon_phy1), .link_pin(link_pin),
    .req(req), .req_phy(req_phy), .req_reg(req_reg), .done(done), .ack(ack),
    .rd_data(rd_data), .host_rd_vld(host_rd_vld), .host_rd_phy(host_rd_phy),
    .host_rd_ack(host_rd_ack), .int_clr_vld(int_clr_vld), .int_clr(int_clr),
    .link_map(link_map), .alive_map(alive_map), .int_raw(int_raw), .int_masked(int_masked)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int next_en(input int last, input logic [31:0] m);
    for (int k = 1; k <= 32; k++) if (m[(last + k) % 32]) return (last + k) % 32;
    return -1;
  endfunction

  // lsel: 0 -> link 0, 1 -> link 1, 2 -> same as stored, 3 -> inverse of stored
  task automatic serve(input bit a, input int lsel, input int hold, output int got);
    int w = 0;
    bit l;
    while (!req && w < 200) begin @(negedge clk); w++; end
    if (!req) begin
      chk(0, "R2", "request timeout", 0, 1);
      got = -1;
      return;
    end
    got = int'(req_phy);
    chk(req_reg == 5'd1, "R2", "status register address", req_reg, 1);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(req && req_phy == got[4:0], "R2", "request held until done", req_phy, got);
    end
    case (lsel)
      0: l = 1'b0;
      1: l = 1'b1;
      2: l = elink[got];
      default: l = ~elink[got];
    endcase
    done = 1'b1; ack = a;
    rd_data = (16'hA5A1 & ~16'h0004) | (16'(l) << 2);
    @(negedge clk);
    done = 1'b0; ack = 1'b0;
    ealive[got] = a;
    if (a) elink[got] = l;
  endtask

  task automatic clear_int(input logic [1:0] m);
    int_clr_vld = 1'b1; int_clr = m;
    @(negedge clk);
    int_clr_vld = 1'b0; int_clr = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int got, last, z, o, seen;
    bit a;
    int l;
    logic [31:0] m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req == 0 && link_map == 0 && alive_map == 0 && int_raw == 0, "R1",
        "reset state", {req, link_map, alive_map}, 0);

    poll_mask = '1;
    seen = 0;
    repeat (8) begin @(negedge clk); if (req) seen++; end
    chk(seen == 0, "R1", "no request while disabled", seen, 0);

    scan_en = 1'b1;
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 32; i++) begin
        a = ((i * 7 + p) % 5) != 0;
        l = ((i >> 1) ^ i ^ p) & 1;
        serve(a, l, i % 3, got);
        chk(got == i, "R2", "ascending order with wrap", got, i);
        chk(alive_map == ealive, a ? "R4" : "R5", "alive bitmap", alive_map, ealive);
        chk(link_map == elink, a ? "R4" : "R5", "link bitmap", link_map, elink);
      end

    last = 31;
    for (int mi = 0; mi < 3; mi++) begin
      case (mi)
        0: m = 32'h8000_0011;
        1: m = 32'h0000_0400;
        default: m = 32'h5555_0000;
      endcase
      poll_mask = m;
      for (int k = 0; k < 6; k++) begin
        serve(1'b1, 2, k % 2, got);
        chk(got == next_en(last, m), "R3", "next enabled address", got, next_en(last, m));
        last = got;
      end
    end

    poll_mask = '0;
    seen = 0;
    repeat (40) begin @(negedge clk); if (req) seen++; end
    chk(seen == 0, "R3", "no request with empty mask", seen, 0);
    scan_en = 1'b0;
    poll_mask = '1;
    @(negedge clk);

    for (int h = 0; h < 4; h++) begin
      host_rd_vld = 1'b1; host_rd_phy = 5'(h * 9 + 2); host_rd_ack = ~ealive[h * 9 + 2];
      ealive[h * 9 + 2] = host_rd_ack;
      @(negedge clk);
      host_rd_vld = 1'b0;
      chk(alive_map == ealive, "R6", "host read updates alive", alive_map, ealive);
    end

    z = -1; o = -1;
    for (int i = 0; i < 32; i++) begin
      if (!elink[i] && z < 0) z = i;
      if (elink[i] && o < 0) o = i;
    end
    mon_sel = 2'b01; mon_int_en = 2'b01; mon_phy0 = 5'd0; mon_phy1 = 5'(z);
    link_pin = 2'b00;
    repeat (2) @(negedge clk);
    clear_int(2'b11);
    chk(int_raw == 0, "R11", "clear all", int_raw, 0);

    link_pin[0] = 1'b1;
    @(negedge clk);
    chk(int_raw == 2'b01, "R8", "pin change raises raw", int_raw, 1);
    chk(int_masked == 2'b01, "R9", "masked follows enabled raw", int_masked, 1);

    link_pin[1] = 1'b1;
    @(negedge clk);
    chk(int_raw == 2'b01, "R7", "unselected pin ignored", int_raw, 1);
    clear_int(2'b01);
    chk(int_raw == 0, "R11", "clear bit 0", int_raw, 0);

    mon_phy1 = 5'(o);
    @(negedge clk);
    chk(int_raw == 2'b10, "R7", "polled source change", int_raw, 2);
    chk(int_masked == 2'b00, "R9", "disabled channel not masked", int_masked, 0);

    mon_sel[1] = 1'b1;
    @(negedge clk);
    chk(int_raw == 2'b10, "R8", "same level no new change", int_raw, 2);
    clear_int(2'b10);
    chk(int_raw == 0, "R11", "clear bit 1", int_raw, 0);
    link_pin[1] = 1'b0;
    @(negedge clk);
    chk(int_raw == 2'b10, "R7", "pin source for channel 1", int_raw, 2);
    clear_int(2'b10);

    link_pin[0] = 1'b0; int_clr_vld = 1'b1; int_clr = 2'b01;
    @(negedge clk);
    int_clr_vld = 1'b0; int_clr = '0;
    chk(int_raw == 2'b01, "R11", "set beats clear", int_raw, 1);
    clear_int(2'b11);

    any_change_mode = 1'b1;
    link_pin[0] = 1'b1;
    @(negedge clk);
    chk(int_raw == 0, "R10", "channel change ignored", int_raw, 0);
    scan_en = 1'b1;
    serve(1'b1, 2, 0, got);
    chk(int_raw == 0, "R10", "same link no interrupt", int_raw, 0);
    serve(1'b1, 3, 1, got);
    chk(int_raw == 2'b01, "R10", "flipped link raises raw 0", int_raw, 1);
    chk(int_masked == 2'b01, "R9", "masked in change mode", int_masked, 1);
    clear_int(2'b01);
    serve(1'b0, 3, 0, got);
    chk(int_raw == 0, "R10", "no ack no interrupt", int_raw, 0);
    chk(link_map == elink, "R5", "link kept on no ack", link_map, elink);
    scan_en = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule